// File: doc/BRIEF.md
# Vertical Transfer Clock Sequencer

This block drives the thirteen vertical transfer clock phases that move lines of charge in an image sensor towards its horizontal output register. The waveforms are not decoded from one fixed counter. They are assembled from four nested layers of programmable tables:

- **Pulse patterns** hold up to four toggle points per phase inside one line.
- **Sequences** each pick one pattern and add a per-phase start level, a pixel offset and a repeat count.
- **Fields** are cut into up to nine regions, and each region plays one sequence.
- **A field order list** chains up to seven fields, in any order, into one readout.

Software fills the tables through a simple write port, working upwards from patterns to sequences to regions to the field order. Every write lands in a staging copy. The staging copy becomes active only when a frame start strobe arrives while the block is idle. The host then supplies one line sync pulse per sensor line. Both the line counter and the pixel counter restart at each line sync. When the last listed field has run out of lines, the block raises a one-clock done pulse and waits for the next frame start.

Top module: `vt_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, all phase outputs are 0 and both busy and frame_done are 0. All toggle slots reset to 0xFFF and every other table entry resets to 0.
- R2: Writes are decoded with wr_addr[11:9] as the table code.
  - Code 0 is a toggle slot: pattern wr_addr[7:6], phase wr_addr[5:2], slot wr_addr[1:0], with the position in data[11:0].
  - Code 1 is a sequence: sequence wr_addr[3:1] and word wr_addr[0]. Word 0 holds the start levels in data[12:0] (bit j is phase j) and the pattern in data[17:16]. Word 1 holds the pixel offset in data[11:0] and the repeat count in data[27:16].
  - Code 2 is a region: field wr_addr[6:4] and region wr_addr[3:0] (0..8). It holds the start line in data[11:0], the sequence in data[18:16] and an enable in data[24].
  - Code 3 is a field length in lines: field wr_addr[2:0], value in data[11:0].
  - Code 4 is the field order list: address 0..6 holds a field number in data[2:0], and address 7 holds the number of fields used in data[2:0].
- R3: A frame start while idle makes busy high one cycle later. Phase outputs stay 0 until the first line sync.
- R4: When a line sync is sampled at edge E0 and the line falls in an enabled region, every phase takes the sequence start level after edge E1.
- R5: While a line is playing, phase j inverts after edge E(2+offset+p) for every slot of phase j whose position p is not 0xFFF. A slot holding 0xFFF never causes a toggle.
- R6: A region plays its pattern on its first N lines, where N is the repeat count of its sequence. On the later lines of that region, the phases hold the start levels for the whole line.
- R7: The active region is the highest-numbered enabled region whose start line is at or below the current line. Entering a region restarts its repeat count. A line that lies in no region drives all phases to 0.
- R8: A field ends after its programmed number of lines. At the line sync that would be one line past that count, the next field in the order list begins at its line 0.
- R9: At the line sync that ends the last field in the list, frame_done is high for exactly one cycle and busy falls at the same edge. All phases are 0 from the next cycle on.
- R10: Writes change the running readout only after the next frame start that is accepted while idle.
- R11: A frame start that arrives while busy is ignored. The running readout continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the staging tables |
| wr_addr | input | 12 | Table code and entry index |
| wr_data | input | 32 | Write data |
| frame_start | input | 1 | One-cycle frame start strobe |
| line_sync | input | 1 | One-cycle horizontal line sync |
| vphase | output | 13 | Vertical transfer clock phases |
| busy | output | 1 | High while a readout is running |
| frame_done | output | 1 | One-cycle pulse at the end of a readout |

## Verification
The assertions assume the following about the inputs:
- line_sync and frame_start are single-cycle pulses that never arrive in the same cycle.
- Every line spans more clocks than its latest toggle point.
- Every field in the order list has a non-zero length.
- Region start lines rise with the region number.

The bench keeps to these assumptions. It separates every strobe by several idle cycles, spaces line syncs about a dozen clocks apart, and programs only ascending regions and lengths of two to four lines. Inside those limits it checks the done pulse, the idle-low outputs and the way frame starts are accepted or ignored depending on busy.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

  localparam logic [2:0] TBL_TOG   = 3'd0;
  localparam logic [2:0] TBL_SEQ   = 3'd1;
  localparam logic [2:0] TBL_RGN   = 3'd2;
  localparam logic [2:0] TBL_FLEN  = 3'd3;
  localparam logic [2:0] TBL_ORDER = 3'd4;

  localparam int SEQ_PAT_LSB = 16;
  localparam int SEQ_REP_LSB = 16;
  localparam int RGN_SEQ_LSB = 16;
  localparam int RGN_EN_BIT  = 24;
endpackage

// File: rtl/vt_regfile.sv
module vt_regfile
  import vt_pkg::*;
#(
  parameter int NUM_OUT  = 13,
  parameter int NUM_TOG  = 4,
  parameter int NUM_PAT  = 4,
  parameter int NUM_SEQ  = 8,
  parameter int NUM_FLD  = 8,
  parameter int NUM_RGN  = 9,
  parameter int MODE_LEN = 7,
  parameter int PIX_W    = 12,
  parameter int LINE_W   = 12,
  parameter int REP_W    = 12,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  localparam int PAT_W   = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1,
  localparam int OUT_W   = $clog2(NUM_OUT),
  localparam int TOG_W   = (NUM_TOG > 1) ? $clog2(NUM_TOG) : 1,
  localparam int SEQ_W   = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1,
  localparam int FLD_W   = (NUM_FLD > 1) ? $clog2(NUM_FLD) : 1,
  localparam int RGN_W   = $clog2(NUM_RGN),
  localparam int MSL_W   = $clog2(MODE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [PIX_W-1:0]  a_tog  [NUM_PAT][NUM_OUT][NUM_TOG],
  output logic [NUM_OUT-1:0] a_pol [NUM_SEQ],
  output logic [PAT_W-1:0]  a_pat  [NUM_SEQ],
  output logic [PIX_W-1:0]  a_sst  [NUM_SEQ],
  output logic [REP_W-1:0]  a_rep  [NUM_SEQ],
  output logic [LINE_W-1:0] a_rln  [NUM_FLD][NUM_RGN],
  output logic [SEQ_W-1:0]  a_rsq  [NUM_FLD][NUM_RGN],
  output logic              a_ren  [NUM_FLD][NUM_RGN],
  output logic [LINE_W-1:0] a_flen [NUM_FLD],
  output logic [FLD_W-1:0]  a_ord  [MODE_LEN],
  output logic [MSL_W-1:0]  a_olen
);
  // staging copies
  logic [PIX_W-1:0]   s_tog  [NUM_PAT][NUM_OUT][NUM_TOG];
  logic [NUM_OUT-1:0] s_pol  [NUM_SEQ];
  logic [PAT_W-1:0]   s_pat  [NUM_SEQ];
  logic [PIX_W-1:0]   s_sst  [NUM_SEQ];
  logic [REP_W-1:0]   s_rep  [NUM_SEQ];
  logic [LINE_W-1:0]  s_rln  [NUM_FLD][NUM_RGN];
  logic [SEQ_W-1:0]   s_rsq  [NUM_FLD][NUM_RGN];
  logic               s_ren  [NUM_FLD][NUM_RGN];
  logic [LINE_W-1:0]  s_flen [NUM_FLD];
  logic [FLD_W-1:0]   s_ord  [MODE_LEN];
  logic [MSL_W-1:0]   s_olen;

  logic [2:0]       tbl;
  logic [TOG_W-1:0] t_i;
  logic [OUT_W-1:0] o_i;
  logic [PAT_W-1:0] p_i;
  logic [SEQ_W-1:0] q_i;
  logic             q_word;
  logic [RGN_W-1:0] r_i;
  logic [FLD_W-1:0] rf_i;
  logic [FLD_W-1:0] f_i;
  logic [MSL_W-1:0] m_i;

  assign tbl    = wr_addr[ADDR_W-1 -: 3];
  assign t_i    = wr_addr[TOG_W-1:0];
  assign o_i    = wr_addr[TOG_W +: OUT_W];
  assign p_i    = wr_addr[TOG_W+OUT_W +: PAT_W];
  assign q_word = wr_addr[0];
  assign q_i    = wr_addr[1 +: SEQ_W];
  assign r_i    = wr_addr[RGN_W-1:0];
  assign rf_i   = wr_addr[RGN_W +: FLD_W];
  assign f_i    = wr_addr[FLD_W-1:0];
  assign m_i    = wr_addr[MSL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PAT; p++)
        for (int o = 0; o < NUM_OUT; o++)
          for (int t = 0; t < NUM_TOG; t++)
            s_tog[p][o][t] <= '1;
      for (int s = 0; s < NUM_SEQ; s++) begin
        s_pol[s] <= '0;
        s_pat[s] <= '0;
        s_sst[s] <= '0;
        s_rep[s] <= '0;
      end
      for (int f = 0; f < NUM_FLD; f++) begin
        s_flen[f] <= '0;
        for (int r = 0; r < NUM_RGN; r++) begin
          s_rln[f][r] <= '0;
          s_rsq[f][r] <= '0;
          s_ren[f][r] <= 1'b0;
        end
      end
      for (int m = 0; m < MODE_LEN; m++) s_ord[m] <= '0;
      s_olen <= '0;
    end else if (wr_en) begin
      case (tbl)
        TBL_TOG: begin
          if (int'(o_i) < NUM_OUT && int'(p_i) < NUM_PAT && int'(t_i) < NUM_TOG)
            s_tog[p_i][o_i][t_i] <= wr_data[PIX_W-1:0];
        end
        TBL_SEQ: begin
          if (int'(q_i) < NUM_SEQ) begin
            if (!q_word) begin
              s_pol[q_i] <= wr_data[NUM_OUT-1:0];
              s_pat[q_i] <= wr_data[SEQ_PAT_LSB +: PAT_W];
            end else begin
              s_sst[q_i] <= wr_data[PIX_W-1:0];
              s_rep[q_i] <= wr_data[SEQ_REP_LSB +: REP_W];
            end
          end
        end
        TBL_RGN: begin
          if (int'(r_i) < NUM_RGN && int'(rf_i) < NUM_FLD) begin
            s_rln[rf_i][r_i] <= wr_data[LINE_W-1:0];
            s_rsq[rf_i][r_i] <= wr_data[RGN_SEQ_LSB +: SEQ_W];
            s_ren[rf_i][r_i] <= wr_data[RGN_EN_BIT];
          end
        end
        TBL_FLEN: begin
          if (int'(f_i) < NUM_FLD) s_flen[f_i] <= wr_data[LINE_W-1:0];
        end
        TBL_ORDER: begin
          if (int'(m_i) < MODE_LEN) s_ord[m_i] <= wr_data[FLD_W-1:0];
          else if (int'(m_i) == MODE_LEN) s_olen <= wr_data[MSL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // active copies, loaded only at an accepted frame start
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PAT; p++)
        for (int o = 0; o < NUM_OUT; o++)
          for (int t = 0; t < NUM_TOG; t++)
            a_tog[p][o][t] <= '1;
      for (int s = 0; s < NUM_SEQ; s++) begin
        a_pol[s] <= '0;
        a_pat[s] <= '0;
        a_sst[s] <= '0;
        a_rep[s] <= '0;
      end
      for (int f = 0; f < NUM_FLD; f++) begin
        a_flen[f] <= '0;
        for (int r = 0; r < NUM_RGN; r++) begin
          a_rln[f][r] <= '0;
          a_rsq[f][r] <= '0;
          a_ren[f][r] <= 1'b0;
        end
      end
      for (int m = 0; m < MODE_LEN; m++) a_ord[m] <= '0;
      a_olen <= '0;
    end else if (commit) begin
      a_tog  <= s_tog;
      a_pol  <= s_pol;
      a_pat  <= s_pat;
      a_sst  <= s_sst;
      a_rep  <= s_rep;
      a_rln  <= s_rln;
      a_rsq  <= s_rsq;
      a_ren  <= s_ren;
      a_flen <= s_flen;
      a_ord  <= s_ord;
      a_olen <= s_olen;
    end
  end
endmodule

// File: rtl/vt_line_ctrl.sv
module vt_line_ctrl
  import vt_pkg::*;
#(
  parameter int NUM_SEQ  = 8,
  parameter int NUM_FLD  = 8,
  parameter int NUM_RGN  = 9,
  parameter int MODE_LEN = 7,
  parameter int LINE_W   = 12,
  parameter int REP_W    = 12,
  localparam int SEQ_W   = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1,
  localparam int FLD_W   = (NUM_FLD > 1) ? $clog2(NUM_FLD) : 1,
  localparam int RGN_W   = $clog2(NUM_RGN),
  localparam int MSL_W   = $clog2(MODE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_sync,
  input  logic [REP_W-1:0]  a_rep  [NUM_SEQ],
  input  logic [LINE_W-1:0] a_rln  [NUM_FLD][NUM_RGN],
  input  logic [SEQ_W-1:0]  a_rsq  [NUM_FLD][NUM_RGN],
  input  logic              a_ren  [NUM_FLD][NUM_RGN],
  input  logic [LINE_W-1:0] a_flen [NUM_FLD],
  input  logic [FLD_W-1:0]  a_ord  [MODE_LEN],
  input  logic [MSL_W-1:0]  a_olen,
  output logic              commit,
  output logic              busy,
  output logic              frame_done,
  output logic              line_go,
  output logic              in_rgn,
  output logic              play,
  output logic [SEQ_W-1:0]  seq_q
);
  localparam logic [MSL_W-1:0] ORDER_CAP = MSL_W'(MODE_LEN);

  run_state_t        state;
  logic              started;
  logic [MSL_W-1:0]  slot_q;
  logic [FLD_W-1:0]  fld_q;
  logic [LINE_W-1:0] line_q;
  logic [RGN_W-1:0]  rgn_q;
  logic              rgn_vld_q;
  logic [REP_W-1:0]  rcnt_q;

  logic              step;
  logic              fresh;
  logic              finish;
  logic [MSL_W-1:0]  slot_inc;
  logic [MSL_W-1:0]  slot_n;
  logic [FLD_W-1:0]  fld_n;
  logic [LINE_W-1:0] line_inc;
  logic [LINE_W-1:0] line_n;
  logic              hit;
  logic [RGN_W-1:0]  ridx;
  logic              entry;
  logic [REP_W-1:0]  cnt_n;
  logic [SEQ_W-1:0]  seq_n;
  logic              play_n;

  assign commit = frame_start && (state == ST_IDLE);
  assign step   = line_sync && (state == ST_RUN);
  assign busy   = (state == ST_RUN);

  // next field / line position at this line sync
  always_comb begin
    slot_inc = slot_q + 1'b1;
    line_inc = line_q + 1'b1;
    fresh    = 1'b0;
    finish   = 1'b0;
    slot_n   = slot_q;
    fld_n    = fld_q;
    line_n   = line_inc;
    if (!started) begin
      fresh  = 1'b1;
      slot_n = '0;
      fld_n  = a_ord[0];
      line_n = '0;
    end else if (line_inc == a_flen[fld_q]) begin
      if (slot_inc >= a_olen || slot_inc >= ORDER_CAP) begin
        finish = 1'b1;
      end else begin
        fresh  = 1'b1;
        slot_n = slot_inc;
        fld_n  = a_ord[slot_inc[MSL_W-1:0]];
        line_n = '0;
      end
    end
  end

  // region lookup: highest enabled region already reached
  always_comb begin
    hit  = 1'b0;
    ridx = '0;
    for (int r = 0; r < NUM_RGN; r++) begin
      if (a_ren[fld_n][r] && a_rln[fld_n][r] <= line_n) begin
        hit  = 1'b1;
        ridx = RGN_W'(r);
      end
    end
  end

  always_comb begin
    entry  = fresh || !rgn_vld_q || (ridx != rgn_q);
    if (entry) cnt_n = '0;
    else if (rcnt_q != '1) cnt_n = rcnt_q + 1'b1;
    else cnt_n = rcnt_q;
    seq_n  = a_rsq[fld_n][ridx];
    play_n = hit && (cnt_n < a_rep[seq_n]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      started    <= 1'b0;
      slot_q     <= '0;
      fld_q      <= '0;
      line_q     <= '0;
      rgn_q      <= '0;
      rgn_vld_q  <= 1'b0;
      rcnt_q     <= '0;
      frame_done <= 1'b0;
      line_go    <= 1'b0;
      in_rgn     <= 1'b0;
      play       <= 1'b0;
      seq_q      <= '0;
    end else begin
      frame_done <= 1'b0;
      line_go    <= 1'b0;
      if (commit) begin
        state     <= ST_RUN;
        started   <= 1'b0;
        rgn_vld_q <= 1'b0;
        play      <= 1'b0;
        in_rgn    <= 1'b0;
      end else if (step) begin
        line_go <= 1'b1;
        if (finish) begin
          state      <= ST_IDLE;
          started    <= 1'b0;
          frame_done <= 1'b1;
          in_rgn     <= 1'b0;
          play       <= 1'b0;
          rgn_vld_q  <= 1'b0;
        end else begin
          started   <= 1'b1;
          slot_q    <= slot_n;
          fld_q     <= fld_n;
          line_q    <= line_n;
          rgn_q     <= ridx;
          rgn_vld_q <= hit;
          rcnt_q    <= cnt_n;
          in_rgn    <= hit;
          play      <= play_n;
          seq_q     <= seq_n;
        end
      end
    end
  end
endmodule

// File: rtl/vt_phase_gen.sv
module vt_phase_gen #(
  parameter int NUM_OUT = 13,
  parameter int NUM_TOG = 4,
  parameter int NUM_PAT = 4,
  parameter int PIX_W   = 12,
  localparam int PAT_W  = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_go,
  input  logic               in_rgn,
  input  logic               play,
  input  logic [PIX_W-1:0]   a_tog [NUM_PAT][NUM_OUT][NUM_TOG],
  input  logic [PAT_W-1:0]   pat_sel,
  input  logic [NUM_OUT-1:0] pol,
  input  logic [PIX_W-1:0]   sst,
  output logic [NUM_OUT-1:0] vphase
);
  logic [PIX_W-1:0]   pix_q;
  logic [NUM_OUT-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) pix_q <= '0;
    else if (line_go) pix_q <= '0;
    else if (pix_q != '1) pix_q <= pix_q + 1'b1;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_phase
    always_comb begin
      hit[o] = 1'b0;
      for (int t = 0; t < NUM_TOG; t++) begin
        if (a_tog[pat_sel][o][t] != '1 &&
            {1'b0, pix_q} == ({1'b0, sst} + {1'b0, a_tog[pat_sel][o][t]}))
          hit[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vphase <= '0;
    else if (line_go) vphase <= in_rgn ? pol : '0;
    else if (play) vphase <= vphase ^ hit;
  end
endmodule

// File: rtl/vt_sequencer.sv
module vt_sequencer #(
  parameter int NUM_OUT  = 13,
  parameter int NUM_TOG  = 4,
  parameter int NUM_PAT  = 4,
  parameter int NUM_SEQ  = 8,
  parameter int NUM_FLD  = 8,
  parameter int NUM_RGN  = 9,
  parameter int MODE_LEN = 7,
  parameter int PIX_W    = 12,
  parameter int LINE_W   = 12,
  parameter int REP_W    = 12,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               frame_start,
  input  logic               line_sync,
  output logic [NUM_OUT-1:0] vphase,
  output logic               busy,
  output logic               frame_done
);
  localparam int PAT_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
  localparam int SEQ_W = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1;
  localparam int FLD_W = (NUM_FLD > 1) ? $clog2(NUM_FLD) : 1;
  localparam int MSL_W = $clog2(MODE_LEN + 1);

  logic [PIX_W-1:0]   a_tog  [NUM_PAT][NUM_OUT][NUM_TOG];
  logic [NUM_OUT-1:0] a_pol  [NUM_SEQ];
  logic [PAT_W-1:0]   a_pat  [NUM_SEQ];
  logic [PIX_W-1:0]   a_sst  [NUM_SEQ];
  logic [REP_W-1:0]   a_rep  [NUM_SEQ];
  logic [LINE_W-1:0]  a_rln  [NUM_FLD][NUM_RGN];
  logic [SEQ_W-1:0]   a_rsq  [NUM_FLD][NUM_RGN];
  logic               a_ren  [NUM_FLD][NUM_RGN];
  logic [LINE_W-1:0]  a_flen [NUM_FLD];
  logic [FLD_W-1:0]   a_ord  [MODE_LEN];
  logic [MSL_W-1:0]   a_olen;

  logic             commit;
  logic             line_go;
  logic             in_rgn;
  logic             play;
  logic [SEQ_W-1:0] seq_q;

  vt_regfile #(
    .NUM_OUT(NUM_OUT), .NUM_TOG(NUM_TOG), .NUM_PAT(NUM_PAT), .NUM_SEQ(NUM_SEQ),
    .NUM_FLD(NUM_FLD), .NUM_RGN(NUM_RGN), .MODE_LEN(MODE_LEN), .PIX_W(PIX_W),
    .LINE_W(LINE_W), .REP_W(REP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit),
    .a_tog(a_tog), .a_pol(a_pol), .a_pat(a_pat), .a_sst(a_sst), .a_rep(a_rep),
    .a_rln(a_rln), .a_rsq(a_rsq), .a_ren(a_ren), .a_flen(a_flen),
    .a_ord(a_ord), .a_olen(a_olen)
  );

  vt_line_ctrl #(
    .NUM_SEQ(NUM_SEQ), .NUM_FLD(NUM_FLD), .NUM_RGN(NUM_RGN), .MODE_LEN(MODE_LEN),
    .LINE_W(LINE_W), .REP_W(REP_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_sync(line_sync),
    .a_rep(a_rep), .a_rln(a_rln), .a_rsq(a_rsq), .a_ren(a_ren),
    .a_flen(a_flen), .a_ord(a_ord), .a_olen(a_olen),
    .commit(commit), .busy(busy), .frame_done(frame_done),
    .line_go(line_go), .in_rgn(in_rgn), .play(play), .seq_q(seq_q)
  );

  vt_phase_gen #(
    .NUM_OUT(NUM_OUT), .NUM_TOG(NUM_TOG), .NUM_PAT(NUM_PAT), .PIX_W(PIX_W)
  ) u_phase (
    .clk(clk), .rst(rst), .line_go(line_go), .in_rgn(in_rgn), .play(play),
    .a_tog(a_tog), .pat_sel(a_pat[seq_q]), .pol(a_pol[seq_q]), .sst(a_sst[seq_q]),
    .vphase(vphase)
  );
endmodule

// File: rtl/vt_sequencer_chk.sv
module vt_sequencer_chk #(
  parameter int NUM_OUT = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic               line_sync,
  input logic [NUM_OUT-1:0] vphase,
  input logic               busy,
  input logic               frame_done
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vphase == '0 && !busy && !frame_done)); // R1

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy && frame_start) |=> busy); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && frame_start && !line_sync) |=> busy); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R9

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> frame_done); // R9

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (vphase == '0)); // R9
endmodule

bind vt_sequencer vt_sequencer_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .line_sync(line_sync),
  .vphase(vphase), .busy(busy), .frame_done(frame_done)
);

// File: tb/vt_sequencer_test.sv
module vt_sequencer_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic        frame_start;
  logic        line_sync;
  logic [12:0] vphase;
  logic        busy;
  logic        frame_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vt_sequencer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .line_sync(line_sync),
    .vphase(vphase), .busy(busy), .frame_done(frame_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_fs();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  // pulse line sync, then sample after edges E1..E8
  task automatic line_chk(input string req, input logic [12:0] e [8]);
    @(negedge clk) line_sync = 1'b1;
    @(negedge clk) line_sync = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk($sformatf("%s E%0d", req, k + 1), 32'(vphase), 32'(e[k]));
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic end_chk(input string req);
    @(negedge clk) line_sync = 1'b1;
    @(negedge clk) line_sync = 1'b0;
    chk({req, " done pulse"}, 32'(frame_done), 32'd1);
    chk({req, " busy low"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk({req, " done cleared"}, 32'(frame_done), 32'd0);
    chk({req, " phases low"}, 32'(vphase), 32'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    frame_start = 1'b0; line_sync = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 phases in reset", 32'(vphase), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 phases after reset", 32'(vphase), 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(frame_done), 32'd0);
  endtask

  // R2 address map used below
  task automatic t_program();
    wr(12'h000, 32'd2);            // pat0 ph0 slot0 = 2
    wr(12'h001, 32'd5);            // pat0 ph0 slot1 = 5
    wr(12'h004, 32'd3);            // pat0 ph1 slot0 = 3
    wr(12'h048, 32'd1);            // pat1 ph2 slot0 = 1
    wr(12'h200, 32'h0000_0002);    // seq0 levels ph1, pat0
    wr(12'h201, 32'h0002_0000);    // seq0 offset 0, rep 2
    wr(12'h202, 32'h0001_0000);    // seq1 levels 0, pat1
    wr(12'h203, 32'h0001_0004);    // seq1 offset 4, rep 1
    wr(12'h420, 32'h0100_0000);    // fld2 rgn0 line0 seq0
    wr(12'h421, 32'h0101_0002);    // fld2 rgn1 line2 seq1
    wr(12'h450, 32'h0101_0000);    // fld5 rgn0 line0 seq1
    wr(12'h602, 32'd4);            // fld2 length 4
    wr(12'h605, 32'd2);            // fld5 length 2
    wr(12'h800, 32'd2);            // order[0] = fld2
    wr(12'h801, 32'd5);            // order[1] = fld5
    wr(12'h807, 32'd2);            // two fields
    repeat (3) @(negedge clk);
    chk("R10 idle before frame", 32'(busy), 32'd0);
  endtask

  task automatic t_frame1();
    pulse_fs();
    chk("R3 busy after start", 32'(busy), 32'd1);
    chk("R3 phases low before line", 32'(vphase), 32'd0);
    line_chk("R4/R5 fld2 line0", '{13'h002, 13'h002, 13'h002, 13'h003,
                                   13'h001, 13'h001, 13'h000, 13'h000});
    // staged edits for the next frame
    wr(12'h000, 32'h0000_0FFF);
    wr(12'h204, 32'h0000_1001);
    wr(12'h205, 32'h0001_0001);
    wr(12'h460, 32'h0102_0001);
    wr(12'h606, 32'd3);
    wr(12'h800, 32'd6);
    wr(12'h807, 32'd1);
    line_chk("R10/R6 fld2 line1 old pattern", '{13'h002, 13'h002, 13'h002, 13'h003,
                                                13'h001, 13'h001, 13'h000, 13'h000});
    line_chk("R7 fld2 line2 rgn1", '{13'h000, 13'h000, 13'h000, 13'h000,
                                     13'h000, 13'h000, 13'h004, 13'h004});
    pulse_fs();
    chk("R11 start ignored while busy", 32'(busy), 32'd1);
    line_chk("R6/R11 fld2 line3 hold", '{13'h000, 13'h000, 13'h000, 13'h000,
                                         13'h000, 13'h000, 13'h000, 13'h000});
    line_chk("R8 fld5 line0", '{13'h000, 13'h000, 13'h000, 13'h000,
                                13'h000, 13'h000, 13'h004, 13'h004});
    line_chk("R6 fld5 line1 hold", '{13'h000, 13'h000, 13'h000, 13'h000,
                                     13'h000, 13'h000, 13'h000, 13'h000});
    end_chk("R9 frame1");
  endtask

  task automatic t_frame2();
    pulse_fs();
    chk("R3 busy frame2", 32'(busy), 32'd1);
    line_chk("R7 fld6 line0 no region", '{13'h000, 13'h000, 13'h000, 13'h000,
                                          13'h000, 13'h000, 13'h000, 13'h000});
    line_chk("R2/R10/R5 fld6 line1 new pattern", '{13'h1001, 13'h1001, 13'h1001, 13'h1001,
                                                   13'h1001, 13'h1003, 13'h1003, 13'h1002});
    line_chk("R6 fld6 line2 hold", '{13'h1001, 13'h1001, 13'h1001, 13'h1001,
                                     13'h1001, 13'h1001, 13'h1001, 13'h1001});
    end_chk("R9 frame2");
  endtask

  initial begin
    t_reset();
    t_program();
    t_frame1();
    t_frame2();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule